// File: doc/BRIEF.md
# Golomb-Rice Coder with Multi-Stream Packer

This block takes prediction residues that have already been mapped to non-negative integers, one sample per handshake. Each sample carries a Rice parameter, a channel number, a precision code and a raw flag. A sample without the raw flag becomes a variable-length Golomb-Rice codeword. A sample with the raw flag is copied as plain bits at its stated precision. Very long unary prefixes are replaced by an escape: a fixed run of ones followed by the sample itself.

The channel number picks one of four signal-type streams: EEG, HRV, DOT or EKG. Each stream has its own bit accumulator. Once an accumulator holds at least one output word of bits, the block offers that word on a valid/ready output together with a two-bit stream ID. Bits beyond the word stay behind for the next word. If several accumulators are full at once, a fixed priority chooses which one goes first.

Codeword lengths vary, so the block throttles its input. The single coded-sample register frees up only when the target accumulator has room. The output state machine has two states. In S_IDLE no word is offered; it moves to S_SEND as soon as any lane is full, capturing that lane's head word. In S_SEND the word is held until it is accepted. On acceptance the machine stays in S_SEND if another lane is full, capturing the next word in the same cycle, and otherwise returns to S_IDLE.

Top module: `gr_stream_packer`

## Requirements
- R1: For a non-raw sample with mapped value v and parameter k (0..15), let q = v >> k. If q < 24, the codeword is q ones, then a zero, then the k low bits of v, most significant first, for a length of q+1+k bits.
- R2: If q >= 24, the codeword is an escape: 24 ones, then v masked to its precision width, most significant first. A sample with q = 23 still uses the normal form of R1.
- R3: A raw sample (in_raw = 1) is packed as v masked to its precision width, most significant first. The precision codes 0..7 select widths of 8, 10, 12, 14, 16, 18, 20 and 32 bits.
- R4: Channels 0-3 go to stream EEG (ID 0), channel 4 to HRV (ID 1), channel 5 to DOT (ID 2), and channels 6-15 to EKG (ID 3). Every output word carries the ID of its stream on out_type.
- R5: Each stream's bit sequence is cut into 16-bit words. The earliest bit lands in bit 15. A word is offered only when its stream holds 16 or more bits, and surplus bits carry over in order.
- R6: When several streams are full at the moment a word is captured, the order is EKG, then EEG, then HRV, then DOT.
- R7: While out_valid is high and out_ready is low, out_valid, out_word and out_type stay unchanged. Every word is delivered exactly once.
- R8: in_ready is low while a coded sample waits for a full stream. No accepted sample is lost under back-pressure.
- R9: After reset, out_valid is 0, in_ready is 1 and all streams are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_value | input | DATA_W | Mapped residue, or raw sample when in_raw is set |
| in_k | input | K_W | Rice parameter |
| in_chan | input | 4 | Channel number (selects the stream) |
| in_prec | input | 3 | Precision code |
| in_raw | input | 1 | Pack the sample raw instead of coding it |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | WORD_W | Packed payload, earliest bit in the MSB |
| out_type | output | 2 | Stream ID of the payload |

## Verification
The bound checker watches several properties on every cycle: that a stalled output holds steady, that a full EKG or EEG lane wins the next capture over lower-priority lanes, that input is refused while the staged codeword's lane is full, that no word appears without a full lane, and that codeword lengths stay in range.

The exact bit patterns need the directed scenarios. These cover the normal, escape and raw forms, the q = 23 boundary against q = 24, the channel-to-stream map, carry-over of surplus bits and the delivery order after a multi-lane stall. The bench compares the words against its own per-stream bit model.

// File: rtl/gr_pkg.sv
`timescale 1ns/1ps
package gr_pkg;

    localparam int N_STREAM = 4;

    typedef enum logic [1:0] {
        ST_EEG = 2'd0,
        ST_HRV = 2'd1,
        ST_DOT = 2'd2,
        ST_EKG = 2'd3
    } stream_t;

    // Channel number to signal-type stream.
    function automatic stream_t chan_stream(input logic [3:0] ch);
        if (ch <= 4'd3)      return ST_EEG;
        else if (ch == 4'd4) return ST_HRV;
        else if (ch == 4'd5) return ST_DOT;
        else                 return ST_EKG;
    endfunction

    // Precision code to sample width in bits.
    function automatic logic [5:0] prec_bits(input logic [2:0] p);
        logic [5:0] w;
        unique case (p)
            3'd0: w = 6'd8;
            3'd1: w = 6'd10;
            3'd2: w = 6'd12;
            3'd3: w = 6'd14;
            3'd4: w = 6'd16;
            3'd5: w = 6'd18;
            3'd6: w = 6'd20;
            3'd7: w = 6'd32;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/gr_encode.sv
`timescale 1ns/1ps
module gr_encode
    import gr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int K_W    = 4,
    parameter int ESC_Q  = 24,
    parameter int CODE_W = 56,
    parameter int LEN_W  = 6
) (
    input  logic [DATA_W-1:0] value,
    input  logic [K_W-1:0]    k,
    input  logic [2:0]        prec,
    input  logic              raw,
    output logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);

    logic [LEN_W-1:0]  width;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] quot;
    logic [DATA_W-1:0] rem_mask;
    logic [DATA_W-1:0] rem;
    logic [CODE_W-1:0] unary;
    logic [CODE_W-1:0] esc_pre;

    always_comb begin
        width = LEN_W'(prec_bits(prec));
        if (int'(width) >= DATA_W)
            masked = value;
        else
            masked = value & ((DATA_W'(1) << width) - DATA_W'(1));

        quot     = value >> k;
        rem_mask = (DATA_W'(1) << k) - DATA_W'(1);
        rem      = value & rem_mask;
        unary    = (CODE_W'(1) << quot[LEN_W-1:0]) - CODE_W'(1);
        esc_pre  = ((CODE_W'(1) << ESC_Q) - CODE_W'(1)) << width;

        if (raw) begin
            code = CODE_W'(masked);
            len  = width;
        end else if (quot >= DATA_W'(ESC_Q)) begin
            code = esc_pre | CODE_W'(masked);
            len  = LEN_W'(ESC_Q) + width;
        end else begin
            code = (unary << (LEN_W'(k) + LEN_W'(1))) | CODE_W'(rem);
            len  = quot[LEN_W-1:0] + LEN_W'(k) + LEN_W'(1);
        end
    end

endmodule

// File: rtl/gr_lane.sv
`timescale 1ns/1ps
module gr_lane #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 56,
    parameter int LEN_W  = 6,
    parameter int BUF_W  = 71,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app,
    input  logic [CODE_W-1:0] app_code,
    input  logic [LEN_W-1:0]  app_len,
    input  logic              pop,
    output logic              full,
    output logic [WORD_W-1:0] head
);

    logic [BUF_W-1:0] acc_q;
    logic [BUF_W-1:0] placed;
    logic [CNT_W-1:0] cnt_q;

    // Left-align the code, then slide it behind the bits already held.
    always_comb begin
        placed = (BUF_W'(app_code) << (CNT_W'(BUF_W) - CNT_W'(app_len))) >> cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (app) begin
            acc_q <= acc_q | placed;
            cnt_q <= cnt_q + CNT_W'(app_len);
        end else if (pop) begin
            acc_q <= acc_q << WORD_W;
            cnt_q <= cnt_q - CNT_W'(WORD_W);
        end
    end

    assign full = (cnt_q >= CNT_W'(WORD_W));
    assign head = acc_q[BUF_W-1 -: WORD_W];

endmodule

// File: rtl/gr_stream_packer.sv
`timescale 1ns/1ps
module gr_stream_packer
    import gr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int K_W    = 4,
    parameter int WORD_W = 16,
    parameter int ESC_Q  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_value,
    input  logic [K_W-1:0]    in_k,
    input  logic [3:0]        in_chan,
    input  logic [2:0]        in_prec,
    input  logic              in_raw,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [1:0]        out_type
);

    localparam int CODE_W = ESC_Q + DATA_W;
    localparam int LEN_W  = $clog2(CODE_W + 1);
    localparam int BUF_W  = WORD_W - 1 + CODE_W;
    localparam int CNT_W  = $clog2(BUF_W + 1);

    typedef enum logic {S_IDLE, S_SEND} ostate_t;

    // Coder stage
    logic [CODE_W-1:0] enc_code;
    logic [LEN_W-1:0]  enc_len;
    logic              c_valid;
    logic [CODE_W-1:0] c_code;
    logic [LEN_W-1:0]  c_len;
    stream_t           c_type;
    logic              take;

    // Lanes
    logic [N_STREAM-1:0] lane_full;
    logic [N_STREAM-1:0] lane_app;
    logic [N_STREAM-1:0] lane_pop;
    logic [WORD_W-1:0]   lane_head [N_STREAM];

    // Output FSM
    ostate_t           st_q, st_d;
    logic              latch;
    logic              any_full;
    stream_t           sel;
    logic [WORD_W-1:0] word_q;
    stream_t           type_q;

    gr_encode #(
        .DATA_W (DATA_W),
        .K_W    (K_W),
        .ESC_Q  (ESC_Q),
        .CODE_W (CODE_W),
        .LEN_W  (LEN_W)
    ) u_enc (
        .value (in_value),
        .k     (in_k),
        .prec  (in_prec),
        .raw   (in_raw),
        .code  (enc_code),
        .len   (enc_len)
    );

    assign take     = c_valid && !lane_full[c_type];
    assign in_ready = !c_valid || take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_valid <= 1'b0;
            c_code  <= '0;
            c_len   <= '0;
            c_type  <= ST_EEG;
        end else if (in_valid && in_ready) begin
            c_valid <= 1'b1;
            c_code  <= enc_code;
            c_len   <= enc_len;
            c_type  <= chan_stream(in_chan);
        end else if (take) begin
            c_valid <= 1'b0;
        end
    end

    for (genvar g = 0; g < N_STREAM; g++) begin : g_lane
        assign lane_app[g] = take  && (c_type == stream_t'(g));
        assign lane_pop[g] = latch && (sel    == stream_t'(g));

        gr_lane #(
            .WORD_W (WORD_W),
            .CODE_W (CODE_W),
            .LEN_W  (LEN_W),
            .BUF_W  (BUF_W),
            .CNT_W  (CNT_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .app      (lane_app[g]),
            .app_code (c_code),
            .app_len  (c_len),
            .pop      (lane_pop[g]),
            .full     (lane_full[g]),
            .head     (lane_head[g])
        );
    end

    // Fixed priority: EKG, EEG, HRV, DOT
    always_comb begin
        any_full = |lane_full;
        if (lane_full[ST_EKG])      sel = ST_EKG;
        else if (lane_full[ST_EEG]) sel = ST_EEG;
        else if (lane_full[ST_HRV]) sel = ST_HRV;
        else                        sel = ST_DOT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Next state and capture control
    always_comb begin
        st_d  = st_q;
        latch = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (any_full) begin
                    latch = 1'b1;
                    st_d  = S_SEND;
                end
            end
            S_SEND: begin
                if (out_ready) begin
                    if (any_full) latch = 1'b1;
                    else          st_d  = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            type_q <= ST_EEG;
        end else if (latch) begin
            word_q <= lane_head[sel];
            type_q <= sel;
        end
    end

    assign out_valid = (st_q == S_SEND);
    assign out_word  = word_q;
    assign out_type  = type_q;

endmodule

// File: rtl/gr_stream_packer_chk.sv
`timescale 1ns/1ps
module gr_stream_packer_chk #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 7,
    parameter int CODE_W = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [1:0]        out_type,
    input logic [3:0]        lane_full,
    input logic              c_valid,
    input logic [1:0]        c_type,
    input logic [LEN_W-1:0]  c_len
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_type)); // R7

    AST_PRIO_EKG: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) && lane_full[3] |=> out_valid && out_type == 2'd3); // R6

    AST_PRIO_EEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) && lane_full[0] && !lane_full[3] |=> out_valid && out_type == 2'd0); // R6

    AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid && lane_full[c_type] |-> !in_ready); // R8

    AST_WORD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !(|lane_full) |=> !out_valid); // R5

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid |-> c_len != '0 && int'(c_len) <= CODE_W); // R1

endmodule

bind gr_stream_packer gr_stream_packer_chk #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_type  (out_type),
    .lane_full (lane_full),
    .c_valid   (c_valid),
    .c_type    (c_type),
    .c_len     (c_len)
);

// File: tb/gr_stream_packer_test.sv
`timescale 1ns/1ps
module gr_stream_packer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_value = '0;
    logic [3:0]  in_k = '0;
    logic [3:0]  in_chan = '0;
    logic [2:0]  in_prec = '0;
    logic        in_raw = 1'b0;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_word;
    logic [1:0]  out_type;

    logic        rdy_man = 1'b1;
    logic        rdy_rand = 1'b0;
    logic        rnd_bit = 1'b1;
    logic [15:0] rdy_lfsr = 16'hACE1;

    int n_cmp = 0;
    int n_bad = 0;

    bit          exp_bits [4][8192];
    int          exp_n   [4] = '{default: 0};
    int          exp_pos [4] = '{default: 0};
    logic [15:0] got_w   [4][512];
    int          got_n   [4] = '{default: 0};
    int          got_idx [4] = '{default: 0};
    logic [1:0]  ord     [4096];
    int          ord_n = 0;

    always #2.5 clk = ~clk;

    assign out_ready = rdy_rand ? rnd_bit : rdy_man;

    gr_stream_packer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_value  (in_value),
        .in_k      (in_k),
        .in_chan   (in_chan),
        .in_prec   (in_prec),
        .in_raw    (in_raw),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .out_type  (out_type)
    );

    always @(posedge clk) begin
        #1;
        rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
        rnd_bit  = rdy_lfsr[0] | rdy_lfsr[3];
    end

    // Output monitor: handshake completes at the next rising edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (got_n[out_type] < 512) begin
                got_w[out_type][got_n[out_type]] = out_word;
                got_n[out_type]++;
            end
            if (ord_n < 4096) begin
                ord[ord_n] = out_type;
                ord_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_bit(input int t, input bit b);
        if (exp_n[t] < 8192) begin
            exp_bits[t][exp_n[t]] = b;
            exp_n[t]++;
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [31:0] v, input int k, input int ch,
                         input int p, input bit raw);
        int t;
        int w;
        logic [31:0] mv;
        longint q;
        t = (ch <= 3) ? 0 : (ch == 4) ? 1 : (ch == 5) ? 2 : 3;
        case (p)
            0: w = 8;   1: w = 10;  2: w = 12;  3: w = 14;
            4: w = 16;  5: w = 18;  6: w = 20;  default: w = 32;
        endcase
        mv = v;
        for (int i = w; i < 32; i++) mv[i] = 1'b0;
        q = longint'(v >> k);
        if (raw) begin
            for (int i = w - 1; i >= 0; i--) put_bit(t, mv[i]);
        end else if (q >= 24) begin
            for (int i = 0; i < 24; i++) put_bit(t, 1'b1);
            for (int i = w - 1; i >= 0; i--) put_bit(t, mv[i]);
        end else begin
            for (int i = 0; i < q; i++) put_bit(t, 1'b1);
            put_bit(t, 1'b0);
            for (int i = k - 1; i >= 0; i--) put_bit(t, v[i]);
        end
    endtask

    // Called at rising edge + 1.
    task automatic send(input logic [31:0] v, input int k, input int ch,
                        input int p, input bit raw);
        bit acc;
        in_value = v;
        in_k     = k[3:0];
        in_chan  = ch[3:0];
        in_prec  = p[2:0];
        in_raw   = raw;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
        model(v, k, ch, p, raw);
    endtask

    task automatic drain(input int n);
        rdy_rand = 1'b0;
        rdy_man  = 1'b1;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic verify(input string req);
        logic [15:0] e;
        for (int t = 0; t < 4; t++) begin
            while (got_idx[t] < got_n[t]) begin
                if (exp_pos[t] + 16 > exp_n[t]) begin
                    check(1'b0, req, "surplus word", got_w[t][got_idx[t]], 0);
                end else begin
                    for (int i = 0; i < 16; i++) e[15 - i] = exp_bits[t][exp_pos[t] + i];
                    check(got_w[t][got_idx[t]] == e, req, $sformatf("stream %0d word", t),
                          got_w[t][got_idx[t]], e);
                end
                exp_pos[t] += 16;
                got_idx[t]++;
            end
            check(exp_n[t] - exp_pos[t] < 16, req, $sformatf("stream %0d bits left", t),
                  exp_n[t] - exp_pos[t], 15);
        end
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
        drain(10);
        check(ord_n == 0, "R9", "words after reset", ord_n, 0);
    endtask

    task automatic t_golomb;
        send(32'd5, 1, 0, 4, 1'b0);
        send(32'd0, 0, 1, 4, 1'b0);
        send(32'd37, 3, 2, 4, 1'b0);
        send(32'd9, 2, 3, 4, 1'b0);
        drain(20);
        check(got_n[0] >= 1 && got_w[0][0] == 16'hD7AE, "R1", "first EEG word",
              got_w[0][0], 16'hD7AE);
        send(32'd1000, 6, 0, 4, 1'b0);
        send(32'd65535, 15, 1, 7, 1'b0);
        send(32'd300, 4, 2, 4, 1'b0);
        send(32'd77, 0, 3, 4, 1'b0);
        send(32'd12345, 10, 0, 4, 1'b0);
        drain(30);
        verify("R1");
    endtask

    task automatic t_escape;
        send(32'd24, 0, 6, 0, 1'b0);
        drain(20);
        check(got_n[3] >= 2 && got_w[3][0] == 16'hFFFF, "R2", "escape word 0",
              got_w[3][0], 16'hFFFF);
        check(got_n[3] >= 2 && got_w[3][1] == 16'hFF18, "R2", "escape word 1",
              got_w[3][1], 16'hFF18);
        send(32'd23, 0, 7, 0, 1'b0);
        send(32'h1234_5678, 2, 8, 4, 1'b0);
        send(32'hFFFF_FFFF, 0, 6, 7, 1'b0);
        send(32'd95, 2, 7, 1, 1'b0);
        send(32'd96, 2, 8, 1, 1'b0);
        drain(30);
        verify("R2");
    endtask

    task automatic t_bypass;
        send(32'hDEAD_BEEF, 0, 4, 4, 1'b1);
        drain(20);
        check(got_n[1] >= 1 && got_w[1][0] == 16'hBEEF, "R3", "raw 16-bit word",
              got_w[1][0], 16'hBEEF);
        for (int p = 0; p < 8; p++) send(32'hDEAD_BEEF ^ (p * 32'h0101_0101), 3, 4, p, 1'b1);
        drain(30);
        verify("R3");
    endtask

    task automatic t_chanmap;
        for (int ch = 0; ch < 16; ch++) send(32'h11 * ch, 0, ch, 0, 1'b1);
        for (int ch = 0; ch < 16; ch++) send(32'hFF - ch, 0, ch, 4, 1'b1);
        drain(30);
        verify("R4");
    endtask

    task automatic t_stall;
        logic [15:0] w0;
        logic [1:0]  t0;
        drain(20);
        verify("R8");
        rdy_man = 1'b0;
        send(32'hA5C3, 0, 5, 4, 1'b1);
        send(32'h0F0F, 0, 5, 4, 1'b1);
        send(32'h1357, 0, 5, 4, 1'b1);
        repeat (2) @(posedge clk);
        #1;
        w0 = out_word;
        t0 = out_type;
        check(out_valid == 1'b1, "R7", "valid while stalled", out_valid, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R8", "in_ready under back-pressure", in_ready, 0);
            check(out_word == w0 && out_type == t0 && out_valid, "R7", "held word",
                  out_word, w0);
        end
        @(posedge clk);
        #1;
        rdy_man = 1'b1;
        drain(40);
        verify("R7");
    endtask

    task automatic t_prio;
        int base;
        drain(20);
        verify("R6");
        base = ord_n;
        rdy_man = 1'b0;
        send(32'h1111, 0, 5, 4, 1'b1);
        send(32'h2222, 0, 4, 4, 1'b1);
        send(32'h3333, 0, 2, 4, 1'b1);
        send(32'h4444, 0, 7, 4, 1'b1);
        repeat (4) @(posedge clk);
        #1;
        rdy_man = 1'b1;
        drain(30);
        check(ord_n - base == 4, "R6", "word count", ord_n - base, 4);
        check(ord[base] == 2'd2, "R6", "first (already held)", ord[base], 2);
        check(ord[base + 1] == 2'd3, "R6", "second EKG", ord[base + 1], 3);
        check(ord[base + 2] == 2'd0, "R6", "third EEG", ord[base + 2], 0);
        check(ord[base + 3] == 2'd1, "R6", "fourth HRV", ord[base + 3], 1);
        verify("R6");
    endtask

    task automatic t_mixed;
        logic [31:0] s;
        logic [31:0] v;
        s = 32'h1;
        rdy_rand = 1'b1;
        for (int i = 0; i < 80; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            v = {16'h0, s[31:16]} >> s[20:17];
            send(v, int'(s[7:4]), int'(s[27:24]), int'(s[10:8]), s[13:11] == 3'd0);
        end
        drain(60);
        verify("R5");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_golomb();
        t_escape();
        t_bypass();
        t_chanmap();
        t_stall();
        t_prio();
        t_mixed();
        summary();
        $finish;
    end

    initial begin
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL all watchdog: got %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

endmodule